// File: doc/BRIEF.md
# I2C LCD Segment Loader Slave

This block is the write side of a cascadable LCD segment driver. It watches the two I2C bus lines, finds START and STOP conditions, and accepts write transfers sent to the fixed 7-bit address 0111010. The first byte after START holds the address and the direction bit. The second byte is always a control byte. Every matching device stores that byte and acknowledges it. The bytes that follow are segment data. They go into an eight-entry register array at a segment vector that steps up by one after each byte.

Several devices can share one bus. Each device has a 3-bit strap that names the group of eight segment bytes it owns. All devices acknowledge the address byte and the control byte together. A data byte, however, is stored and acknowledged only by the device whose strap matches the upper vector bits. The other devices still step their vector, so every device keeps the same vector.

After reset the block holds the segment outputs at VSS. A device in master mode also holds its backplane at VSS, and a cascaded device leaves its backplane at high impedance. This blanked state ends when the first control byte arrives.

Top module: `lcd_seg_loader`

## Requirements
- R1: A first byte equal to 0x74 (address 0111010 in bits 7..1, write bit 0 = 0) is acknowledged, whatever the value of `dev_sel_i`.
- R2: If the address differs, or if the direction bit is 1, the byte is not acknowledged. Later bytes are then ignored (no acknowledge, no register change) until the next START.
- R3: The second byte of every addressed transfer is acknowledged and appears on `ctrl_o`. Bit 7 is the mode bit, bit 6 the bank bit, and bits 5..0 the segment vector.
- R4: A data byte is stored in entry `ctrl_o[2:0]` when `ctrl_o[5:3]` equals `dev_sel_i`, and it is acknowledged. Entry i appears on `seg_data_o[8*i+7:8*i]`.
- R5: After every data byte, the vector `ctrl_o[5:0]` increments by one, even on a device that is not selected, and it wraps from 63 to 0.
- R6: A data byte whose upper vector bits differ from `dev_sel_i` is not acknowledged, and no entry changes.
- R7: A STOP that follows the control-byte acknowledge leaves every segment entry unchanged.
- R8: After reset, `ctrl_o` = 0, `seg_data_o` = 0, `sda_oe_o` = 0 and `blank_o` = 1. While blanked, `bp_hiz_o` equals `cascade_i`.
- R9: The first control byte clears `blank_o`. From then on `bp_hiz_o` is 0.
- R10: A repeated START, sent without a STOP, restarts address reception. The next byte is treated as an address.
- R11: `sda_oe_o` rises only after the SCL falling edge that ends bit 8. It falls after the next SCL falling edge, the one that ends the ninth clock. It is low while the bits of a byte are being received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull the data line low (open drain) |
| dev_sel_i | input | 3 | Strap: which eight-byte segment group this device owns |
| cascade_i | input | 1 | 1 = cascaded device, 0 = master device |
| ctrl_o | output | 8 | Control register: mode, bank, vector |
| seg_data_o | output | 64 | Segment register array, entry i in byte i |
| blank_o | output | 1 | Outputs held at VSS until the first control byte |
| bp_hiz_o | output | 1 | Backplane held at high impedance |

## Verification
The assertions assume that SCL is slow next to the system clock, so each bus level lasts several clock cycles. They also assume that SDA changes only while SCL is low, except at START and STOP, and that the master releases SDA during each acknowledge clock. The bench changes each bus line at most once every eight clock cycles. It moves SDA only in the low phase of SCL, except for the START and STOP edges. It models the open-drain line as the AND of the master's drive and the inverse of `sda_oe_o`.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;
  localparam int BYTE_W = 8;
  localparam int VEC_W  = 6;
  localparam int SEL_W  = 3;
  localparam int IDX_W  = VEC_W - SEL_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam logic [6:0] SLV_ADDR = 7'b0111010;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK} rx_state_e;
  typedef enum logic [1:0] {BK_ADDR, BK_CTRL, BK_DATA} byte_kind_e;
endpackage

// File: rtl/lcd_bus_sync.sv
module lcd_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[STAGES-1];
  assign sda_s      = sda_ff[STAGES-1];
  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/lcd_i2c_rx.sv
module lcd_i2c_rx
  import lcd_seg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sel_i,
  output logic              sda_oe_o,
  output logic              ctrl_we_o,
  output logic              data_we_o,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  rx_state_e         state_q, state_d;
  byte_kind_e        kind_q, kind_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic              oe_q, oe_d;
  logic              byte_end, addr_hit;

  assign byte_end  = (state_q == RX_BITS) && (cnt_q == CNT_FULL) && scl_fall_i
                     && !start_i && !stop_i;
  assign addr_hit  = (shift_q == {SLV_ADDR, 1'b0});
  assign ctrl_we_o = byte_end && (kind_q == BK_CTRL);
  assign data_we_o = byte_end && (kind_q == BK_DATA);
  assign byte_o    = shift_q;
  assign sda_oe_o  = oe_q;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    oe_d    = oe_q;
    if (start_i) begin
      state_d = RX_BITS;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (stop_i) begin
      state_d = RX_IDLE;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        RX_BITS: begin
          if (scl_rise_i && cnt_q != CNT_FULL) begin
            shift_d = {shift_q[BYTE_W-2:0], sda_s_i};
            cnt_d   = cnt_q + CNT_W'(1);
          end else if (byte_end) begin
            case (kind_q)
              BK_ADDR: begin
                if (addr_hit) begin
                  oe_d    = 1'b1;
                  state_d = RX_ACK;
                end else begin
                  state_d = RX_IDLE;
                end
              end
              BK_CTRL: begin
                oe_d    = 1'b1;
                state_d = RX_ACK;
              end
              default: begin
                oe_d    = sel_i;
                state_d = RX_ACK;
              end
            endcase
          end
        end
        RX_ACK: begin
          if (scl_fall_i) begin
            oe_d    = 1'b0;
            state_d = RX_BITS;
            cnt_d   = '0;
            kind_d  = (kind_q == BK_ADDR) ? BK_CTRL : BK_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      shift_q <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      oe_q    <= oe_d;
    end
  end

  // R11: acknowledge drive starts only at an SCL falling edge
  p_oe_rise_on_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(scl_fall_i));
  // R11: release happens at an SCL falling edge or a bus condition
  p_oe_fall_on_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_q) |-> $past(scl_fall_i || start_i || stop_i));
  // R10: a START always reopens address reception
  p_restart_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (state_q == RX_BITS && kind_q == BK_ADDR && cnt_q == '0));
  // R6: unselected data byte never pulls SDA
  p_unsel_no_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we_o && !sel_i) |=> !oe_q);
endmodule

// File: rtl/lcd_seg_bank.sv
module lcd_seg_bank
  import lcd_seg_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ctrl_we_i,
  input  logic                    data_we_i,
  input  logic [BYTE_W-1:0]       byte_i,
  input  logic [SEL_W-1:0]        dev_sel_i,
  output logic                    sel_o,
  output logic [BYTE_W-1:0]       ctrl_o,
  output logic [DEPTH*BYTE_W-1:0] seg_flat_o,
  output logic                    blank_o
);
  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic              blank_q, blank_d;

  assign sel_o   = (ctrl_q[VEC_W-1:IDX_W] == dev_sel_i);
  assign ctrl_o  = ctrl_q;
  assign blank_o = blank_q;

  always_comb begin
    ctrl_d  = ctrl_q;
    blank_d = blank_q;
    if (ctrl_we_i) begin
      ctrl_d  = byte_i;
      blank_d = 1'b0;
    end else if (data_we_i) begin
      ctrl_d[VEC_W-1:0] = ctrl_q[VEC_W-1:0] + VEC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      blank_q <= 1'b1;
    end else begin
      ctrl_q  <= ctrl_d;
      blank_q <= blank_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [BYTE_W-1:0] ent_q;
    logic              wr_en;
    assign wr_en = data_we_i && sel_o && (ctrl_q[IDX_W-1:0] == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ent_q <= '0;
      else if (wr_en) ent_q <= byte_i;
    end
    assign seg_flat_o[i*BYTE_W +: BYTE_W] = ent_q;
  end

  // R5: vector steps by one, modulo 64, per data byte
  p_vec_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_we_i |=> ctrl_q[VEC_W-1:0] == VEC_W'($past(ctrl_q[VEC_W-1:0]) + 1));
  // R6: unselected data byte leaves the array untouched
  p_unsel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we_i && !sel_o) |=> $stable(seg_flat_o));
  // R3: control byte lands in the control register
  p_ctrl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we_i |=> ctrl_q == $past(byte_i));
  // R9: blanking ends only with a control byte
  p_blank_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_q) |-> $past(ctrl_we_i));
endmodule

// File: rtl/lcd_seg_loader.sv
module lcd_seg_loader
  import lcd_seg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    scl_i,
  input  logic                    sda_i,
  output logic                    sda_oe_o,
  input  logic [SEL_W-1:0]        dev_sel_i,
  input  logic                    cascade_i,
  output logic [BYTE_W-1:0]       ctrl_o,
  output logic [DEPTH*BYTE_W-1:0] seg_data_o,
  output logic                    blank_o,
  output logic                    bp_hiz_o
);
  logic [1:0]        rst_ff;
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start, stop;
  logic              sel, ctrl_we, data_we, blank;
  logic [BYTE_W-1:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= '0;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_sync_n = rst_ff[1];

  lcd_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  lcd_i2c_rx u_rx (
    .clk(clk), .rst_n(rst_sync_n), .sda_s_i(sda_s), .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall), .start_i(start), .stop_i(stop), .sel_i(sel),
    .sda_oe_o(sda_oe_o), .ctrl_we_o(ctrl_we), .data_we_o(data_we),
    .byte_o(rx_byte)
  );

  lcd_seg_bank u_bank (
    .clk(clk), .rst_n(rst_sync_n), .ctrl_we_i(ctrl_we), .data_we_i(data_we),
    .byte_i(rx_byte), .dev_sel_i(dev_sel_i), .sel_o(sel), .ctrl_o(ctrl_o),
    .seg_flat_o(seg_data_o), .blank_o(blank)
  );

  assign blank_o  = blank;
  assign bp_hiz_o = blank & cascade_i;
endmodule

// File: tb/lcd_seg_loader_tb_top.sv
module lcd_seg_loader_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl_m = 1'b1, sda_m = 1'b1;
  logic        sda_oe;
  logic [2:0]  dev_sel = 3'd2;
  logic        cascade = 1'b1;
  logic [7:0]  ctrl;
  logic [63:0] seg;
  logic        blank, bp_hiz;
  logic        sda_line;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic  exp_q[$];
  string tag_q[$];
  event  ack_ev;

  always #10 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  lcd_seg_loader dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .dev_sel_i(dev_sel), .cascade_i(cascade),
    .ctrl_o(ctrl), .seg_data_o(seg), .blank_o(blank), .bp_hiz_o(bp_hiz)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (8) @(posedge clk);
    #2;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl_m = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  // driver: sends a byte, pushes the expected acknowledge into the scoreboard
  task automatic send_byte(input logic [7:0] b, input logic exp_ack,
                           input string tag);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wait_q();
      scl_m = 1'b1; wait_q();
      if (i == 0) chk(sda_oe == 1'b0, "R11 no drive during bits", sda_oe, 0);
      wait_q();
      scl_m = 1'b0; wait_q();
    end
    sda_m = 1'b1;
    exp_q.push_back(exp_ack);
    tag_q.push_back(tag);
    wait_q();
    scl_m = 1'b1; wait_q();
    -> ack_ev;
    wait_q();
    scl_m = 1'b0; wait_q();
    chk(sda_oe == 1'b0, "R11 release after ninth clock", sda_oe, 0);
  endtask

  // monitor: pops the expected acknowledge and compares with the open-drain drive
  initial begin
    forever begin
      logic  e;
      string t;
      @(ack_ev);
      #1;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(sda_oe == e, t, sda_oe, e);
    end
  end

  function automatic logic [7:0] ent(input int i);
    return seg[8*i +: 8];
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    #2;
    // R8 reset state
    chk(ctrl == 8'h00, "R8 ctrl reset", ctrl, 0);
    chk(seg == 64'h0, "R8 segments reset", seg, 0);
    chk(blank == 1'b1 && sda_oe == 1'b0, "R8 blank and sda", {blank, sda_oe}, 2'b10);
    chk(bp_hiz == 1'b1, "R8 backplane hiz in cascade", bp_hiz, 1);
    cascade = 1'b0; #1;
    chk(bp_hiz == 1'b0, "R8 backplane driven in master", bp_hiz, 0);
    cascade = 1'b1;
    rst_n = 1'b1;
    wait_q();

    // main write: R1 R3 R4 R9
    bus_start();
    send_byte(8'h74, 1'b1, "R1 address ack");
    send_byte(8'hD0, 1'b1, "R3 control ack");
    send_byte(8'hA1, 1'b1, "R4 data ack byte0");
    send_byte(8'hB2, 1'b1, "R4 data ack byte1");
    bus_stop();
    chk(ctrl == 8'hD2, "R3 ctrl fields after two bytes", ctrl, 8'hD2);
    chk(ent(0) == 8'hA1, "R4 entry0", ent(0), 8'hA1);
    chk(ent(1) == 8'hB2, "R4 entry1", ent(1), 8'hB2);
    chk(blank == 1'b0 && bp_hiz == 1'b0, "R9 unblanked", {blank, bp_hiz}, 0);

    // R2 wrong address then R/W=1
    bus_start();
    send_byte(8'h76, 1'b0, "R2 wrong address nack");
    send_byte(8'h05, 1'b0, "R2 ignored byte nack");
    bus_stop();
    chk(ctrl == 8'hD2, "R2 ctrl unchanged", ctrl, 8'hD2);
    bus_start();
    send_byte(8'h75, 1'b0, "R2 read bit nack");
    send_byte(8'h11, 1'b0, "R2 ignored after read");
    bus_stop();
    chk(ctrl == 8'hD2, "R2 ctrl unchanged after read", ctrl, 8'hD2);

    // R6 unselected data, R5 still increments
    bus_start();
    send_byte(8'h74, 1'b1, "R1 address ack again");
    send_byte(8'h00, 1'b1, "R3 control ack when unselected");
    send_byte(8'h55, 1'b0, "R6 unselected nack");
    bus_stop();
    chk(ctrl == 8'h01, "R5 vector steps when unselected", ctrl, 8'h01);
    chk(ent(0) == 8'hA1, "R6 entry0 kept", ent(0), 8'hA1);

    // R7 stop right after control
    bus_start();
    send_byte(8'h74, 1'b1, "R1 address ack bank");
    send_byte(8'h50, 1'b1, "R3 control ack bank");
    bus_stop();
    chk(ctrl == 8'h50, "R7 ctrl bank set", ctrl, 8'h50);
    chk(ent(0) == 8'hA1 && ent(1) == 8'hB2, "R7 segments unchanged",
        seg[15:0], 16'hB2A1);

    // R5 wrap with device 7
    dev_sel = 3'd7;
    bus_start();
    send_byte(8'h74, 1'b1, "R1 address ack dev7");
    send_byte(8'h3E, 1'b1, "R3 control ack dev7");
    send_byte(8'h11, 1'b1, "R4 data ack entry6");
    send_byte(8'h22, 1'b1, "R4 data ack entry7");
    send_byte(8'h33, 1'b0, "R5 wrapped vector unselected");
    bus_stop();
    chk(ent(6) == 8'h11 && ent(7) == 8'h22, "R4 entries 6 and 7",
        seg[63:48], 16'h2211);
    chk(ctrl == 8'h01, "R5 wrap 63 to 0 then 1", ctrl, 8'h01);
    chk(ent(0) == 8'hA1, "R5 wrap did not store", ent(0), 8'hA1);

    // R10 repeated start
    bus_start();
    send_byte(8'h74, 1'b1, "R1 address ack before restart");
    send_byte(8'h38, 1'b1, "R3 control ack before restart");
    bus_start();
    send_byte(8'h74, 1'b1, "R10 address ack after restart");
    send_byte(8'h3A, 1'b1, "R10 control ack after restart");
    send_byte(8'h99, 1'b1, "R10 data ack after restart");
    bus_stop();
    chk(ent(2) == 8'h99, "R10 entry2 written", ent(2), 8'h99);
    chk(ent(0) == 8'hA1, "R10 entry0 untouched", ent(0), 8'hA1);
    chk(ctrl == 8'h3B, "R10 ctrl after restart", ctrl, 8'h3B);

    wait_q();
    finish_run();
  end
endmodule